// File: doc/BRIEF.md
# Programmable Binary Ripple Timer

This block is a programmable timer built on a 24-stage binary divider. It runs on a fast system clock. It samples a slow external timing signal through a synchroniser and advances the divider on every falling edge of that signal. A 4-bit code chooses one of the upper sixteen stages to drive the single timer output. Used freely, the output is a square wave at a power-of-two fraction of the timing signal. Used as a one-shot, the output is forced high by the set control and stays high until the first timing edge after set is released. A bypass control skips the eight fastest stages, which shortens every period by a factor of 256.

The control is a five-state machine. `ST_RUN` is normal counting. `ST_LOW_HOLD` holds the output low and clears the divider while the clear control is high. `ST_HIGH_HOLD` holds the output high and clears the divider while set is high. `ST_ARMED` keeps the output high after set is released and waits for one timing edge. `ST_TEST` splits the divider into three byte-wide sections that count in parallel.

The state changes are these, in priority order. The test request (bypass, set and clear all high) moves any state to `ST_TEST`. Clear alone moves any state to `ST_LOW_HOLD`. Set alone moves any state to `ST_HIGH_HOLD`. When none of these controls is high, each state moves as follows:
- `ST_LOW_HOLD` goes to `ST_RUN`.
- `ST_HIGH_HOLD` goes to `ST_ARMED`.
- `ST_ARMED` goes to `ST_RUN` on a detected falling edge and otherwise stays in `ST_ARMED`.
- `ST_TEST` goes to `ST_RUN`.
- `ST_RUN` stays in `ST_RUN`.

An optional digital pulse stretcher turns each rising edge of the chosen stage into a pulse of a programmable number of system clocks. An oscillator-enable request output tells the surroundings when the timing source may be stopped.

Top module: `prog_ripple_timer`

## Requirements
- R1: The system reset leaves the output low, the divider at zero and the machine in `ST_RUN`. While `clr_i` is high, and the test request is not present, the output is low from the next clock edge on and the divider is zero.
- R2: The timing input passes through a two-flop synchroniser. A falling edge is found by comparing the synchronised sample with the previous sample. The divider increments on the third clock edge after the low level is first sampled. Rising edges of the timing input do not change the divider.
- R3: With `bypass_i` low, code n on `sel_i` selects divider bit 8+n, which is stage 9+n. `sel_i` bit 0 is the least significant bit. The output is then a square wave with 2^(8+n) falling edges high and 2^(8+n) falling edges low.
- R4: With `bypass_i` high, the eight lowest bits of the divider hold their value, and bits 8 to 23 count as a 16-stage counter. Code n then selects stage n+1 of that counter, so the output toggles every 2^n falling edges.
- R5: While `set_i` is high and `clr_i` is low, the output is high from the next edge on and the divider is zero. After set is released, the first falling edge leaves the divider at zero and drives the output low. Counting starts on the second falling edge.
- R6: When `set_i` and `clr_i` are both high while `bypass_i` is low, clear wins: the output is low and the machine is in `ST_LOW_HOLD`.
- R7: While `clk_inh_i` is high, falling edges do not change the divider. The first falling edge after inhibit is released counts.
- R8: `osc_en_o` is low whenever `set_i`, `clr_i` or `osc_inh_i` is high, and high otherwise. It responds combinationally.
- R9: When `bypass_i`, `set_i` and `clr_i` are all high, each falling edge increments the three byte sections (bits 0 to 7, 8 to 15 and 16 to 23) independently, with no carry between them. The output follows the bit that the code selects, as in R3.
- R10: When `pulse_en_i` is high in `ST_RUN` or `ST_TEST`, a rising edge of the selected bit makes the output high for exactly `pulse_len_i` system clocks. The pulse starts one clock after the rise. A new rise restarts the pulse. A length of 0 produces no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous system reset |
| tmr_in | input | 1 | External timing signal; its falling edges advance the divider |
| set_i | input | 1 | Forces the output high and clears the divider |
| clr_i | input | 1 | Forces the output low and clears the divider |
| clk_inh_i | input | 1 | Holds the divider count |
| osc_inh_i | input | 1 | Asks for the timing source to stop |
| bypass_i | input | 1 | Skips the eight lowest divider stages |
| sel_i | input | SEL_W | Stage select code |
| pulse_en_i | input | 1 | Selects pulse-stretch output mode |
| pulse_len_i | input | PLEN_W | Pulse width in system clocks |
| dec_out | output | 1 | Timer output |
| osc_en_o | output | 1 | Timing source enable request |

## Verification
The bench builds the block with its default parameters: 24 stages, 8-bit sections, a 4-bit select code, a 4-bit pulse length and a two-flop synchroniser. With these values, stage 9 toggles after 256 edges, so the select codes without bypass can be checked within a few thousand clocks. The bypass and test modes make the remaining codes, up to bit 23, reachable in a few hundred edges. The 4-bit pulse length lets the bench try a zero length, short lengths, and a pulse that is restarted.

// File: rtl/prt_pkg.sv
package prt_pkg;

    typedef enum logic [2:0] {
        ST_RUN       = 3'd0,
        ST_LOW_HOLD  = 3'd1,
        ST_HIGH_HOLD = 3'd2,
        ST_ARMED     = 3'd3,
        ST_TEST      = 3'd4
    } prt_state_e;

endpackage

// File: rtl/prt_edge_sync.sv
module prt_edge_sync #(
    parameter int SYNC_LEN = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic fall_o
);

    logic [SYNC_LEN-1:0] sync_sh;
    logic                prev_q;
    logic                synced;

    assign synced = sync_sh[SYNC_LEN-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_sh <= '0;
            prev_q  <= 1'b0;
        end else begin
            sync_sh <= {sync_sh[SYNC_LEN-2:0], async_i};
            prev_q  <= synced;
        end
    end

    // A falling edge is a high previous sample followed by a low current sample.
    assign fall_o = prev_q & ~synced;

endmodule

// File: rtl/prt_stage_chain.sv
module prt_stage_chain #(
    parameter int STAGES = 24,
    parameter int SECT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_i,
    input  logic              step_full_i,
    input  logic              step_upper_i,
    input  logic              step_sect_i,
    output logic [STAGES-1:0] cnt_o
);

    localparam int NSECT = STAGES / SECT_W;
    localparam int UPPER = STAGES - SECT_W;

    logic [STAGES-1:0] cnt_q;
    logic [STAGES-1:0] sect_next;

    // In test mode every section counts on its own, with no carry between sections.
    for (genvar g = 0; g < NSECT; g++) begin : g_sect
        assign sect_next[g*SECT_W +: SECT_W] = cnt_q[g*SECT_W +: SECT_W] + SECT_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear_i) begin
            cnt_q <= '0;
        end else if (step_sect_i) begin
            cnt_q <= sect_next;
        end else if (step_upper_i) begin
            cnt_q[STAGES-1:SECT_W] <= cnt_q[STAGES-1:SECT_W] + UPPER'(1);
        end else if (step_full_i) begin
            cnt_q <= cnt_q + STAGES'(1);
        end
    end

    assign cnt_o = cnt_q;

endmodule

// File: rtl/prt_pulse_stretch.sv
module prt_pulse_stretch #(
    parameter int PLEN_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              active_i,
    input  logic              level_i,
    input  logic [PLEN_W-1:0] len_i,
    output logic              pulse_o
);

    logic              level_q;
    logic [PLEN_W-1:0] remain_q;
    logic              rise;

    assign rise = level_i & ~level_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            level_q  <= 1'b0;
            remain_q <= '0;
        end else begin
            level_q <= level_i;
            if (!active_i) begin
                remain_q <= '0;
            end else if (rise) begin
                remain_q <= len_i;
            end else if (remain_q != '0) begin
                remain_q <= remain_q - PLEN_W'(1);
            end
        end
    end

    assign pulse_o = (remain_q != '0);

endmodule

// File: rtl/prt_ctrl_fsm.sv
module prt_ctrl_fsm
    import prt_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       set_i,
    input  logic       clr_i,
    input  logic       bypass_i,
    input  logic       inh_i,
    input  logic       fall_i,
    output prt_state_e state_o,
    output logic       clear_o,
    output logic       step_full_o,
    output logic       step_upper_o,
    output logic       step_sect_o,
    output logic       active_o,
    output logic       force_o,
    output logic       force_lvl_o
);

    prt_state_e state_q, state_d;
    logic       test_req;
    logic       count_ok;

    assign test_req = bypass_i & set_i & clr_i;

    // Next state: the test request wins, then clear, then set.
    always_comb begin
        state_d = state_q;
        if (test_req) begin
            state_d = ST_TEST;
        end else if (clr_i) begin
            state_d = ST_LOW_HOLD;
        end else if (set_i) begin
            state_d = ST_HIGH_HOLD;
        end else begin
            unique case (state_q)
                ST_RUN:       state_d = ST_RUN;
                ST_LOW_HOLD:  state_d = ST_RUN;
                ST_HIGH_HOLD: state_d = ST_ARMED;
                ST_ARMED:     state_d = fall_i ? ST_RUN : ST_ARMED;
                ST_TEST:      state_d = ST_RUN;
                default:      state_d = ST_RUN;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
        end else begin
            state_q <= state_d;
        end
    end

    // Outputs
    always_comb begin
        active_o     = 1'b0;
        force_o      = 1'b0;
        force_lvl_o  = 1'b0;
        unique case (state_q)
            ST_RUN:       active_o = 1'b1;
            ST_TEST:      active_o = 1'b1;
            ST_LOW_HOLD:  force_o  = 1'b1;
            ST_HIGH_HOLD: begin
                force_o     = 1'b1;
                force_lvl_o = 1'b1;
            end
            ST_ARMED: begin
                force_o     = 1'b1;
                force_lvl_o = 1'b1;
            end
            default: force_o = 1'b1;
        endcase
        count_ok     = active_o & fall_i & ~inh_i & ~set_i & ~clr_i;
        clear_o      = ~test_req & (set_i | clr_i);
        step_sect_o  = test_req & fall_i & ~inh_i;
        step_full_o  = count_ok & ~bypass_i;
        step_upper_o = count_ok & bypass_i;
    end

    assign state_o = state_q;

endmodule

// File: rtl/prog_ripple_timer.sv
module prog_ripple_timer
    import prt_pkg::*;
#(
    parameter int STAGES   = 24,
    parameter int SECT_W   = 8,
    parameter int SEL_W    = 4,
    parameter int PLEN_W   = 4,
    parameter int SYNC_LEN = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tmr_in,
    input  logic              set_i,
    input  logic              clr_i,
    input  logic              clk_inh_i,
    input  logic              osc_inh_i,
    input  logic              bypass_i,
    input  logic [SEL_W-1:0]  sel_i,
    input  logic              pulse_en_i,
    input  logic [PLEN_W-1:0] pulse_len_i,
    output logic              dec_out,
    output logic              osc_en_o
);

    localparam int IDX_W = $clog2(STAGES);

    logic              fall;
    logic              clear, step_full, step_upper, step_sect;
    logic              active, force_out, force_lvl;
    logic [STAGES-1:0] cnt_q;
    logic [IDX_W-1:0]  sel_idx;
    logic              sel_bit;
    logic              pulse;
    prt_state_e        state_q;

    prt_edge_sync #(.SYNC_LEN(SYNC_LEN)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (tmr_in),
        .fall_o  (fall)
    );

    prt_ctrl_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .set_i        (set_i),
        .clr_i        (clr_i),
        .bypass_i     (bypass_i),
        .inh_i        (clk_inh_i),
        .fall_i       (fall),
        .state_o      (state_q),
        .clear_o      (clear),
        .step_full_o  (step_full),
        .step_upper_o (step_upper),
        .step_sect_o  (step_sect),
        .active_o     (active),
        .force_o      (force_out),
        .force_lvl_o  (force_lvl)
    );

    prt_stage_chain #(.STAGES(STAGES), .SECT_W(SECT_W)) u_chain (
        .clk          (clk),
        .rst_n        (rst_n),
        .clear_i      (clear),
        .step_full_i  (step_full),
        .step_upper_i (step_upper),
        .step_sect_i  (step_sect),
        .cnt_o        (cnt_q)
    );

    // The code indexes the upper stages. In bypass those stages are the 16-stage counter.
    assign sel_idx = IDX_W'(SECT_W) + IDX_W'(sel_i);
    assign sel_bit = cnt_q[sel_idx];

    prt_pulse_stretch #(.PLEN_W(PLEN_W)) u_pulse (
        .clk      (clk),
        .rst_n    (rst_n),
        .active_i (active),
        .level_i  (sel_bit),
        .len_i    (pulse_len_i),
        .pulse_o  (pulse)
    );

    assign dec_out  = force_out ? force_lvl : (pulse_en_i ? pulse : sel_bit);
    assign osc_en_o = ~(set_i | clr_i | osc_inh_i);

endmodule

// File: rtl/prt_timer_checker.sv
module prt_timer_checker
    import prt_pkg::*;
#(
    parameter int STAGES = 24
) (
    input logic              clk,
    input logic              rst_n,
    input logic              set_i,
    input logic              clr_i,
    input logic              bypass_i,
    input logic              clk_inh_i,
    input logic              osc_inh_i,
    input logic              dec_out,
    input logic              osc_en_o,
    input logic [STAGES-1:0] cnt_q,
    input prt_state_e        state_q
);

    p_clr_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !(bypass_i && set_i)) |=> !dec_out);

    p_clr_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !(bypass_i && set_i)) |=> (cnt_q == '0));

    p_set_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i && !clr_i) |=> dec_out);

    p_armed_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ARMED) |-> (cnt_q == '0));

    p_clr_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i && clr_i && !bypass_i) |=> (state_q == ST_LOW_HOLD));

    p_inhibit_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_inh_i && !set_i && !clr_i) |=> $stable(cnt_q));

    p_standby_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i || clr_i || osc_inh_i) |-> !osc_en_o);

    p_test_entry_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bypass_i && set_i && clr_i) |=> (state_q == ST_TEST));

endmodule

bind prog_ripple_timer prt_timer_checker #(.STAGES(STAGES)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .set_i     (set_i),
    .clr_i     (clr_i),
    .bypass_i  (bypass_i),
    .clk_inh_i (clk_inh_i),
    .osc_inh_i (osc_inh_i),
    .dec_out   (dec_out),
    .osc_en_o  (osc_en_o),
    .cnt_q     (cnt_q),
    .state_q   (state_q)
);

// File: tb/prog_ripple_timer_tb_top.sv
module prog_ripple_timer_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tmr_in = 1'b0;
    logic       set_i = 1'b0, clr_i = 1'b0, clk_inh_i = 1'b0, osc_inh_i = 1'b0;
    logic       bypass_i = 1'b0, pulse_en_i = 1'b0;
    logic [3:0] sel_i = 4'd0;
    logic [3:0] pulse_len_i = 4'd0;
    logic       dec_out, osc_en_o;

    int    n_cmp = 0;
    int    n_bad = 0;
    int    cycles = 0;
    string cur_req = "R1";

    prog_ripple_timer dut_i (
        .clk(clk), .rst_n(rst_n), .tmr_in(tmr_in), .set_i(set_i), .clr_i(clr_i),
        .clk_inh_i(clk_inh_i), .osc_inh_i(osc_inh_i), .bypass_i(bypass_i),
        .sel_i(sel_i), .pulse_en_i(pulse_en_i), .pulse_len_i(pulse_len_i),
        .dec_out(dec_out), .osc_en_o(osc_en_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Behavioural reference: 0 run, 1 low hold, 2 high hold, 3 armed, 4 test
    int          m_state;
    bit [23:0]   m_cnt;
    bit          m_s1, m_s2, m_prev, m_lvl;
    int          m_rem;

    always @(posedge clk or negedge rst_n) begin : model
        bit f, testq, run_like, selb;
        if (!rst_n) begin
            m_state = 0; m_cnt = '0; m_s1 = 0; m_s2 = 0; m_prev = 0; m_lvl = 0; m_rem = 0;
        end else begin
            f        = m_prev && !m_s2;
            testq    = bypass_i && set_i && clr_i;
            run_like = (m_state == 0) || (m_state == 4);
            selb     = m_cnt[8 + int'(sel_i)];
            if (!run_like) m_rem = 0;
            else if (selb && !m_lvl) m_rem = int'(pulse_len_i);
            else if (m_rem > 0) m_rem = m_rem - 1;
            m_lvl = selb;
            if (testq) begin
                if (f && !clk_inh_i)
                    for (int k = 0; k < 3; k++) m_cnt[k*8 +: 8] = m_cnt[k*8 +: 8] + 8'd1;
            end else if (set_i || clr_i) begin
                m_cnt = '0;
            end else if (run_like && f && !clk_inh_i) begin
                if (bypass_i) m_cnt[23:8] = m_cnt[23:8] + 16'd1;
                else          m_cnt = m_cnt + 24'd1;
            end
            if (testq)      m_state = 4;
            else if (clr_i) m_state = 1;
            else if (set_i) m_state = 2;
            else if (m_state == 2) m_state = 3;
            else if (m_state == 3) m_state = f ? 0 : 3;
            else m_state = 0;
            m_prev = m_s2; m_s2 = m_s1; m_s1 = tmr_in;
        end
    end

    function automatic bit exp_dec();
        if (m_state == 1) return 1'b0;
        if (m_state == 2 || m_state == 3) return 1'b1;
        return pulse_en_i ? (m_rem != 0) : m_cnt[8 + int'(sel_i)];
    endfunction

    task automatic compare();
        bit ed, eo;
        ed = exp_dec();
        eo = !(set_i || clr_i || osc_inh_i);
        n_cmp++;
        if (dec_out !== ed) begin
            n_bad++;
            $display("FAIL %s dec_out actual=%b expected=%b t=%0t", cur_req, dec_out, ed, $time);
        end
        n_cmp++;
        if (osc_en_o !== eo) begin
            n_bad++;
            $display("FAIL %s osc_en_o actual=%b expected=%b t=%0t", cur_req, osc_en_o, eo, $time);
        end
    endtask

    always @(negedge clk) begin
        cycles++;
        if (rst_n) begin
            #1 compare();
        end
    end

    task automatic wait_clk(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic edges(int n);
        for (int i = 0; i < n; i++) begin
            tmr_in = 1'b1; wait_clk(2);
            tmr_in = 1'b0; wait_clk(2);
        end
    endtask

    initial begin
        // Watchdog counts as a failed check
        wait (cycles > WATCHDOG);
        n_bad++;
        $display("FAIL watchdog expired actual=%0d expected<=%0d", cycles, WATCHDOG);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        wait_clk(3);
        rst_n = 1'b1;
        cur_req = "R1"; wait_clk(3);
        clr_i = 1; edges(2); clr_i = 0;

        cur_req = "R2"; edges(3);
        cur_req = "R3"; sel_i = 4'd0; edges(600);
        sel_i = 4'd1; edges(120);

        cur_req = "R4"; clr_i = 1; wait_clk(2); clr_i = 0;
        bypass_i = 1;
        for (int s = 0; s < 5; s++) begin sel_i = 4'(s); edges(40); end

        cur_req = "R5"; bypass_i = 0; sel_i = 4'd0;
        set_i = 1; wait_clk(3); set_i = 0; wait_clk(5);
        edges(1); edges(300);
        set_i = 1; bypass_i = 1; wait_clk(2); set_i = 0; edges(6);

        cur_req = "R6"; bypass_i = 0; set_i = 1; clr_i = 1; edges(2);
        set_i = 0; clr_i = 0; bypass_i = 1; sel_i = 4'd1; edges(5);

        cur_req = "R7"; clk_inh_i = 1; edges(6); clk_inh_i = 0; edges(6);
        clk_inh_i = 1; tmr_in = 1; wait_clk(2); clk_inh_i = 0; tmr_in = 0; wait_clk(4); edges(3);

        cur_req = "R8"; osc_inh_i = 1; edges(2); osc_inh_i = 0; wait_clk(2);

        cur_req = "R9"; bypass_i = 1; set_i = 1; clr_i = 1;
        for (int s = 0; s < 16; s += 3) begin sel_i = 4'(s); edges(50); end
        sel_i = 4'd15; edges(140);
        clk_inh_i = 1; edges(3); clk_inh_i = 0;
        set_i = 0; clr_i = 0; edges(4);

        cur_req = "R10"; clr_i = 1; wait_clk(2); clr_i = 0;
        bypass_i = 1; sel_i = 4'd0; pulse_en_i = 1;
        pulse_len_i = 4'd3; edges(12);
        pulse_len_i = 4'd0; edges(8);
        pulse_len_i = 4'd12; edges(10);
        sel_i = 4'd2; pulse_len_i = 4'd5; edges(20);
        pulse_en_i = 0; edges(4);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule